// File: doc/BRIEF.md
# Character Attribute Extension Controller

This block keeps the display attributes that a character-mode display controller applies on top of its glyphs. A host writes a 4-bit extension command, then optionally an X and a Y address. The upper two command bits pick one of four functions: magnification, reverse video, cursor, or character blink. The lower two bits carry that function's setting. The address writes that follow bind the setting either to a character line (magnification, reverse) or to a single character cell (cursor, blink).

The block holds per-line magnification and reverse state for every character line. It also holds a full-screen reverse flag, one cursor position with its mode, and one blink position with its enable. A 1 Hz blink phase is derived from an external 2 Hz tick. The scan logic drives a line index and a cell coordinate on the query pins and reads the resulting attributes combinationally.

Writes arrive on a valid/ready port. Ready is held high, so there is no back-pressure: every cycle with valid high is one accepted write.

Top module: `ext_attr_ctrl`

## Requirements
- R1: A write with wr_sel=0 is a command write. wr_data[3:2] selects the function (0 magnification, 1 reverse, 2 cursor, 3 blink) and wr_data[1:0] is the setting. ext_cmd shows the last accepted command from the next cycle on, and it changes only on a command write.
- R2: While the function is magnification, each Y write (wr_sel=2, line in wr_data[2:0]) sets that line's magnification to the setting. The codes are 0 standard, 1 double width, 2 double height and 3 both. Repeated Y writes extend the setting to more lines.
- R3: While the function is reverse, settings 0 and 1 clear or set the reverse bit of the line named by each Y write. Settings 2 and 3 clear or set a full-screen flag at the command write itself. q_rev is the line bit ORed with the full-screen flag.
- R4: q_rev_rows is 18 when the queried line's magnification has double height (code 2 or 3), and 9 otherwise.
- R5: A cursor command sets cursor_mode to the setting (0 hidden, 1 steady, 2 blinking). The command 4'b1011 is ignored: ext_cmd and cursor_mode keep their values and no pending X is cleared.
- R6: For the cursor and blink functions, a position is committed only by a Y write that follows an X write (wr_sel=1, column in wr_data[4:0]) made under the same command. The commit consumes the X. A Y write with no pending X, or a command write between the X and the Y, leaves the position unchanged.
- R7: A blink command sets blink_en to wr_data[0]; wr_data[1] is don't-care.
- R8: blink_lit toggles on every tick_2hz pulse. scaler_rst forces it to 1 and takes priority over a tick in the same cycle.
- R9: cell_cursor is high when cursor_mode is not hidden, (q_x,q_y) equals the cursor position, and the mode is steady or blink_lit is 1. cell_blank is high when blink_en is set, (q_x,q_y) equals the blink position, and blink_lit is 0.
- R10: After reset, ext_cmd is 0000. All line attributes and the full-screen flag are clear, the cursor is hidden at (0,0), blink is disabled at (0,0), and blink_lit is 1.
- R11: wr_ready is always 1. A write with wr_sel=3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write strobe |
| wr_ready | output | 1 | Always 1 |
| wr_sel | input | 2 | 0 command, 1 X address, 2 Y address, 3 unused |
| wr_data | input | 8 | Write data |
| tick_2hz | input | 1 | One-cycle pulse per 2 Hz edge |
| scaler_rst | input | 1 | Restart blink phase lit |
| q_line | input | 3 | Line queried for line attributes |
| q_x | input | 5 | Cell column queried |
| q_y | input | 3 | Cell line queried |
| ext_cmd | output | 4 | Last accepted command |
| q_mag | output | 2 | Magnification of q_line |
| q_rev | output | 1 | Reverse state of q_line |
| q_rev_rows | output | 5 | Dot rows a reverse of q_line covers |
| cursor_mode | output | 2 | Cursor mode |
| cursor_x | output | 5 | Cursor column |
| cursor_y | output | 3 | Cursor line |
| blink_en | output | 1 | Character blink enabled |
| blink_x | output | 5 | Blink column |
| blink_y | output | 3 | Blink line |
| blink_lit | output | 1 | Blink phase, 1 = lit |
| cell_cursor | output | 1 | Cursor visible at (q_x,q_y) |
| cell_blank | output | 1 | Glyph suppressed at (q_x,q_y) |

## Verification
Directed sequences apply each function in turn. Magnification is written to several lines in a row to show the extension rule. Reverse alternates between line and full-screen forms, which separates the OR from the line bits. Cursor writes are given as Y without X, as X then Y, as a second Y after a commit, and as X interrupted by a command write; these tell a correct commit rule from one that commits too eagerly. Ticks and scaler restarts, including both in the same cycle, then run with queries pinned to the cursor and blink cells. A long random write stream follows, and every output is compared each cycle against a behavioural model.

// File: rtl/ext_attr_pkg.sv
package ext_attr_pkg;
  typedef enum logic [1:0] {FN_MAG = 2'd0, FN_REV = 2'd1, FN_CUR = 2'd2, FN_BLK = 2'd3} ext_fn_e;
  typedef enum logic [1:0] {SEL_CMD = 2'd0, SEL_X = 2'd1, SEL_Y = 2'd2, SEL_NONE = 2'd3} wr_sel_e;
  localparam logic [1:0] CUR_HIDE   = 2'd0;
  localparam logic [1:0] CUR_STEADY = 2'd1;
  localparam logic [1:0] CUR_BLINK  = 2'd2;
  localparam logic [1:0] CUR_BAD    = 2'd3;
endpackage

// File: rtl/ext_cmd_reg.sv
module ext_cmd_reg
  import ext_attr_pkg::*;
#(
  parameter int XW = 5,
  parameter int YW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [1:0]    wr_sel,
  input  logic [7:0]    wr_data,
  output logic [3:0]    cmd,
  output logic          cmd_acc,
  output logic          x_acc,
  output logic          y_acc,
  output logic [XW-1:0] x_val,
  output logic [YW-1:0] y_val
);
  logic bad_cursor;

  // the undefined cursor code is dropped without touching anything
  assign bad_cursor = (wr_data[3:2] == FN_CUR) && (wr_data[1:0] == CUR_BAD);
  assign cmd_acc    = wr_valid && (wr_sel == SEL_CMD) && !bad_cursor;
  assign x_acc      = wr_valid && (wr_sel == SEL_X);
  assign y_acc      = wr_valid && (wr_sel == SEL_Y);
  assign x_val      = wr_data[XW-1:0];
  assign y_val      = wr_data[YW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cmd <= 4'd0;
    else if (cmd_acc) cmd <= wr_data[3:0];
  end
endmodule

// File: rtl/ext_line_attr.sv
module ext_line_attr
  import ext_attr_pkg::*;
#(
  parameter int LINES      = 8,
  parameter int GLYPH_ROWS = 7,
  parameter int YW         = $clog2(LINES),
  parameter int ROWW       = $clog2(2 * (GLYPH_ROWS + 2) + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      cmd,
  input  logic            cmd_acc,
  input  logic [3:0]      cmd_new,
  input  logic            y_acc,
  input  logic [YW-1:0]   y_val,
  input  logic [YW-1:0]   q_line,
  output logic [1:0]      q_mag,
  output logic            q_rev,
  output logic [ROWW-1:0] q_rev_rows
);
  // glyph rows plus cursor row plus top spacer, doubled for tall lines
  localparam int ROWS_STD  = GLYPH_ROWS + 2;
  localparam int ROWS_TALL = 2 * ROWS_STD;

  logic [2*LINES-1:0] mag_flat;
  logic [LINES-1:0]   rev_flat;
  logic               full_rev;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic       hit;
    logic [1:0] mag_q;
    logic       rev_q;
    assign hit = y_acc && (y_val == YW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mag_q <= 2'd0;
        rev_q <= 1'b0;
      end else if (hit) begin
        if (cmd[3:2] == FN_MAG) mag_q <= cmd[1:0];
        if (cmd[3:2] == FN_REV && !cmd[1]) rev_q <= cmd[0];
      end
    end
    assign mag_flat[2*g +: 2] = mag_q;
    assign rev_flat[g]        = rev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_rev <= 1'b0;
    else if (cmd_acc && cmd_new[3:2] == FN_REV && cmd_new[1]) full_rev <= cmd_new[0];
  end

  always_comb begin
    q_mag = 2'd0;
    q_rev = full_rev;
    if (int'(q_line) < LINES) begin
      q_mag = mag_flat[2*q_line +: 2];
      q_rev = rev_flat[q_line] | full_rev;
    end
    q_rev_rows = q_mag[1] ? ROWW'(ROWS_TALL) : ROWW'(ROWS_STD);
  end
endmodule

// File: rtl/ext_pos_track.sv
module ext_pos_track
  import ext_attr_pkg::*;
#(
  parameter int         XW   = 5,
  parameter int         YW   = 3,
  parameter logic [1:0] OWNER = FN_CUR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    fn,
  input  logic          cmd_acc,
  input  logic          x_acc,
  input  logic          y_acc,
  input  logic [XW-1:0] x_val,
  input  logic [YW-1:0] y_val,
  output logic [XW-1:0] pos_x,
  output logic [YW-1:0] pos_y
);
  logic          x_pend;
  logic [XW-1:0] x_hold;
  logic          mine;

  assign mine = (fn == OWNER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_pend <= 1'b0;
      x_hold <= '0;
      pos_x  <= '0;
      pos_y  <= '0;
    end else if (cmd_acc) begin
      x_pend <= 1'b0;
    end else if (x_acc && mine) begin
      x_pend <= 1'b1;
      x_hold <= x_val;
    end else if (y_acc && mine && x_pend) begin
      pos_x  <= x_hold;
      pos_y  <= y_val;
      x_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/ext_blink_base.sv
module ext_blink_base (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_2hz,
  input  logic scaler_rst,
  output logic lit
);
  // each 2 Hz edge flips the phase, giving a 1 Hz square wave
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lit <= 1'b1;
    else if (scaler_rst) lit <= 1'b1;
    else if (tick_2hz)   lit <= ~lit;
  end
endmodule

// File: rtl/ext_attr_ctrl.sv
module ext_attr_ctrl
  import ext_attr_pkg::*;
#(
  parameter int LINES      = 8,
  parameter int XW         = 5,
  parameter int GLYPH_ROWS = 7,
  localparam int YW        = $clog2(LINES),
  localparam int ROWW      = $clog2(2 * (GLYPH_ROWS + 2) + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  output logic            wr_ready,
  input  logic [1:0]      wr_sel,
  input  logic [7:0]      wr_data,
  input  logic            tick_2hz,
  input  logic            scaler_rst,
  input  logic [YW-1:0]   q_line,
  input  logic [XW-1:0]   q_x,
  input  logic [YW-1:0]   q_y,
  output logic [3:0]      ext_cmd,
  output logic [1:0]      q_mag,
  output logic            q_rev,
  output logic [ROWW-1:0] q_rev_rows,
  output logic [1:0]      cursor_mode,
  output logic [XW-1:0]   cursor_x,
  output logic [YW-1:0]   cursor_y,
  output logic            blink_en,
  output logic [XW-1:0]   blink_x,
  output logic [YW-1:0]   blink_y,
  output logic            blink_lit,
  output logic            cell_cursor,
  output logic            cell_blank
);
  logic          cmd_acc, x_acc, y_acc;
  logic [XW-1:0] x_val;
  logic [YW-1:0] y_val;

  assign wr_ready = 1'b1;

  ext_cmd_reg #(.XW(XW), .YW(YW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sel(wr_sel), .wr_data(wr_data),
    .cmd(ext_cmd), .cmd_acc(cmd_acc), .x_acc(x_acc), .y_acc(y_acc),
    .x_val(x_val), .y_val(y_val)
  );

  ext_line_attr #(.LINES(LINES), .GLYPH_ROWS(GLYPH_ROWS), .YW(YW), .ROWW(ROWW)) u_line (
    .clk(clk), .rst_n(rst_n), .cmd(ext_cmd), .cmd_acc(cmd_acc), .cmd_new(wr_data[3:0]),
    .y_acc(y_acc), .y_val(y_val), .q_line(q_line),
    .q_mag(q_mag), .q_rev(q_rev), .q_rev_rows(q_rev_rows)
  );

  ext_pos_track #(.XW(XW), .YW(YW), .OWNER(FN_CUR)) u_cur_pos (
    .clk(clk), .rst_n(rst_n), .fn(ext_cmd[3:2]), .cmd_acc(cmd_acc),
    .x_acc(x_acc), .y_acc(y_acc), .x_val(x_val), .y_val(y_val),
    .pos_x(cursor_x), .pos_y(cursor_y)
  );

  ext_pos_track #(.XW(XW), .YW(YW), .OWNER(FN_BLK)) u_blk_pos (
    .clk(clk), .rst_n(rst_n), .fn(ext_cmd[3:2]), .cmd_acc(cmd_acc),
    .x_acc(x_acc), .y_acc(y_acc), .x_val(x_val), .y_val(y_val),
    .pos_x(blink_x), .pos_y(blink_y)
  );

  ext_blink_base u_phase (
    .clk(clk), .rst_n(rst_n), .tick_2hz(tick_2hz), .scaler_rst(scaler_rst), .lit(blink_lit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cursor_mode <= CUR_HIDE;
      blink_en    <= 1'b0;
    end else if (cmd_acc) begin
      if (wr_data[3:2] == FN_CUR) cursor_mode <= wr_data[1:0];
      if (wr_data[3:2] == FN_BLK) blink_en    <= wr_data[0];
    end
  end

  logic at_cursor, at_blink;
  assign at_cursor   = (q_x == cursor_x) && (q_y == cursor_y);
  assign at_blink    = (q_x == blink_x) && (q_y == blink_y);
  assign cell_cursor = at_cursor && (cursor_mode == CUR_STEADY ||
                                     (cursor_mode == CUR_BLINK && blink_lit));
  assign cell_blank  = at_blink && blink_en && !blink_lit;
endmodule

// File: rtl/ext_attr_ctrl_chk.sv
module ext_attr_ctrl_chk #(
  parameter int XW   = 5,
  parameter int YW   = 3,
  parameter int ROWW = 5,
  parameter int TALL = 18
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_valid,
  input logic [1:0]      wr_sel,
  input logic [7:0]      wr_data,
  input logic            tick_2hz,
  input logic            scaler_rst,
  input logic [3:0]      ext_cmd,
  input logic [1:0]      q_mag,
  input logic [ROWW-1:0] q_rev_rows,
  input logic [1:0]      cursor_mode,
  input logic [XW-1:0]   cursor_x,
  input logic [YW-1:0]   cursor_y,
  input logic            blink_lit,
  input logic            cell_blank
);
  AST_CMD_ONLY_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_sel == 2'd0) |=> $stable(ext_cmd)); // R1
  AST_TALL_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
    q_mag[1] |-> (q_rev_rows == ROWW'(TALL))); // R4
  AST_BAD_CURSOR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_sel == 2'd0 && wr_data[3:0] == 4'b1011) |=> ($stable(ext_cmd) && $stable(cursor_mode))); // R5
  AST_CURSOR_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cursor_mode != 2'b11); // R5
  AST_POS_NEEDS_Y: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_sel == 2'd2) |=> ($stable(cursor_x) && $stable(cursor_y))); // R6
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_2hz && !scaler_rst) |=> $stable(blink_lit)); // R8
  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    scaler_rst |=> blink_lit); // R8
  AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_2hz && !scaler_rst) |=> (blink_lit != $past(blink_lit))); // R8
  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    cell_blank |-> !blink_lit); // R9
endmodule

bind ext_attr_ctrl ext_attr_ctrl_chk #(.XW(XW), .YW(YW), .ROWW(ROWW), .TALL(2 * (GLYPH_ROWS + 2))) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sel(wr_sel), .wr_data(wr_data),
  .tick_2hz(tick_2hz), .scaler_rst(scaler_rst), .ext_cmd(ext_cmd), .q_mag(q_mag),
  .q_rev_rows(q_rev_rows), .cursor_mode(cursor_mode), .cursor_x(cursor_x),
  .cursor_y(cursor_y), .blink_lit(blink_lit), .cell_blank(cell_blank)
);

// File: tb/ext_attr_ctrl_bench.sv
module ext_attr_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       tick_2hz = 1'b0;
  logic       scaler_rst = 1'b0;
  logic [2:0] q_line = 3'd0;
  logic [4:0] q_x = 5'd0;
  logic [2:0] q_y = 3'd0;
  logic [3:0] ext_cmd;
  logic [1:0] q_mag;
  logic       q_rev;
  logic [4:0] q_rev_rows;
  logic [1:0] cursor_mode;
  logic [4:0] cursor_x, blink_x;
  logic [2:0] cursor_y, blink_y;
  logic       blink_en, blink_lit, cell_cursor, cell_blank;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ext_attr_ctrl u_ext_attr_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_sel(wr_sel),
    .wr_data(wr_data), .tick_2hz(tick_2hz), .scaler_rst(scaler_rst), .q_line(q_line),
    .q_x(q_x), .q_y(q_y), .ext_cmd(ext_cmd), .q_mag(q_mag), .q_rev(q_rev),
    .q_rev_rows(q_rev_rows), .cursor_mode(cursor_mode), .cursor_x(cursor_x),
    .cursor_y(cursor_y), .blink_en(blink_en), .blink_x(blink_x), .blink_y(blink_y),
    .blink_lit(blink_lit), .cell_cursor(cell_cursor), .cell_blank(cell_blank)
  );

  // behavioural reference state
  int m_cmd = 0, m_full = 0, m_cmode = 0, m_ben = 0, m_lit = 1;
  int m_xp = 0, m_xv = 0, m_cx = 0, m_cy = 0, m_bx = 0, m_by = 0;
  int m_mag[8] = '{default: 0};
  int m_rev[8] = '{default: 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cmd = 0; m_full = 0; m_cmode = 0; m_ben = 0; m_lit = 1;
      m_xp = 0; m_xv = 0; m_cx = 0; m_cy = 0; m_bx = 0; m_by = 0;
      for (int i = 0; i < 8; i++) begin m_mag[i] = 0; m_rev[i] = 0; end
    end else begin
      if (wr_valid) begin
        int f, s, y;
        f = wr_data[3:2]; s = wr_data[1:0]; y = wr_data[2:0];
        if (wr_sel == 0 && !(f == 2 && s == 3)) begin
          m_cmd = wr_data[3:0]; m_xp = 0;
          if (f == 1 && s >= 2) m_full = s - 2;
          if (f == 2) m_cmode = s;
          if (f == 3) m_ben = s % 2;
        end else if (wr_sel == 1) begin
          m_xv = wr_data[4:0];
          if (m_cmd >= 8) m_xp = 1;
        end else if (wr_sel == 2) begin
          case (m_cmd / 4)
            0: m_mag[y] = m_cmd % 4;
            1: if ((m_cmd % 4) < 2) m_rev[y] = m_cmd % 2;
            2: if (m_xp) begin m_cx = m_xv; m_cy = y; m_xp = 0; end
            default: if (m_xp) begin m_bx = m_xv; m_by = y; m_xp = 0; end
          endcase
        end
      end
      if (scaler_rst) m_lit = 1;
      else if (tick_2hz) m_lit = 1 - m_lit;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // compare every output against the model once per cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e_cc, e_cb;
      e_cc = (q_x == m_cx && q_y == m_cy && (m_cmode == 1 || (m_cmode == 2 && m_lit == 1))) ? 1 : 0;
      e_cb = (q_x == m_bx && q_y == m_by && m_ben == 1 && m_lit == 0) ? 1 : 0;
      chk("R1", "ext_cmd", ext_cmd, m_cmd);
      chk("R2", "q_mag", q_mag, m_mag[q_line]);
      chk("R3", "q_rev", q_rev, (m_rev[q_line] | m_full));
      chk("R4", "q_rev_rows", q_rev_rows, (m_mag[q_line] >= 2) ? 18 : 9);
      chk("R5", "cursor_mode", cursor_mode, m_cmode);
      chk("R6", "cursor_pos", {cursor_x, cursor_y}, {m_cx[4:0], m_cy[2:0]});
      chk("R6", "blink_pos", {blink_x, blink_y}, {m_bx[4:0], m_by[2:0]});
      chk("R7", "blink_en", blink_en, m_ben);
      chk("R8", "blink_lit", blink_lit, m_lit);
      chk("R9", "cell_cursor", cell_cursor, e_cc);
      chk("R9", "cell_blank", cell_blank, e_cb);
      chk("R11", "wr_ready", wr_ready, 1);
    end
  end

  // query driver: sweep lines, often aim at the cursor or blink cell
  always @(posedge clk) begin
    #2;
    q_line <= q_line + 3'd1;
    case ($urandom_range(0, 2))
      0: begin q_x <= m_cx[4:0]; q_y <= m_cy[2:0]; end
      1: begin q_x <= m_bx[4:0]; q_y <= m_by[2:0]; end
      default: begin q_x <= 5'($urandom_range(0, 21)); q_y <= 3'($urandom_range(0, 7)); end
    endcase
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_valid = 1'b1; wr_sel = s; wr_data = d;
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic pulse(input logic t, input logic r);
    tick_2hz = t; scaler_rst = r;
    @(posedge clk); #1;
    tick_2hz = 1'b0; scaler_rst = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3); #1;
    rst_n = 1'b1;
    #2;
    // R10 reset values
    chk("R10", "ext_cmd", ext_cmd, 0);
    chk("R10", "cursor_mode", cursor_mode, 0);
    chk("R10", "blink_en", blink_en, 0);
    chk("R10", "blink_lit", blink_lit, 1);
    chk("R10", "q_mag", q_mag, 0);
    chk("R10", "q_rev", q_rev, 0);
    chk("R10", "cursor_pos", {cursor_x, cursor_y}, 0);
    idle(2);
    // R2 magnification on a run of lines
    wr(2'd0, 8'h03); wr(2'd2, 8'd2); wr(2'd2, 8'd3);
    wr(2'd0, 8'h01); wr(2'd2, 8'd5);
    wr(2'd0, 8'h02); wr(2'd2, 8'd6);
    idle(10);
    // R3 line and full-screen reverse
    wr(2'd0, 8'h05); wr(2'd2, 8'd1); idle(8);
    wr(2'd0, 8'h07); idle(8);
    wr(2'd0, 8'h06); idle(8);
    wr(2'd0, 8'h04); wr(2'd2, 8'd1); idle(8);
    // R5 R6 cursor modes and commit order
    wr(2'd0, 8'h09); wr(2'd2, 8'd4); idle(2);
    wr(2'd1, 8'd10); wr(2'd2, 8'd3); idle(2);
    wr(2'd2, 8'd6); idle(2);
    wr(2'd0, 8'h0B); idle(2);
    wr(2'd0, 8'h0A); wr(2'd1, 8'd7); wr(2'd0, 8'h0A); wr(2'd2, 8'd2); idle(2);
    wr(2'd1, 8'd21); wr(2'd3, 8'h55); wr(2'd2, 8'd7); idle(4);
    // R7 R8 R9 blink position and phase
    wr(2'd0, 8'h0F); wr(2'd1, 8'd3); wr(2'd2, 8'd1);
    repeat (5) begin pulse(1'b1, 1'b0); idle(2); end
    pulse(1'b0, 1'b1); idle(2);
    pulse(1'b1, 1'b0); pulse(1'b1, 1'b1); idle(2);
    wr(2'd0, 8'h0E); idle(4);
    // random stream
    for (int i = 0; i < 6000; i++) begin
      wr_valid   = ($urandom_range(0, 2) != 0);
      wr_sel     = 2'($urandom_range(0, 3));
      wr_data    = 8'($urandom);
      if (wr_sel == 2'd1) wr_data = 8'($urandom_range(0, 21));
      tick_2hz   = ($urandom_range(0, 5) == 0);
      scaler_rst = ($urandom_range(0, 30) == 0);
      @(posedge clk); #1;
    end
    wr_valid = 1'b0; tick_2hz = 1'b0; scaler_rst = 1'b0;
    idle(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule